// File: doc/BRIEF.md
# Bank Decoder with Boot Overlay

This block decodes every bus request on a 32-bit address space into four equal 1 GiB banks and checks it against the privilege of the current processor mode. A granted request raises exactly one chip select, for boot ROM, user RAM, kernel RAM or I/O. A refused request raises a single-cycle fault indication and no chip select. The privilege is bit 7 of the processor's 8-bit status byte, where 1 means kernel mode. The page permission for user accesses comes from a separate page checker through the `page_ok` input.

Right after reset, the lowest bank is an alias of the boot ROM, so the reset vector fetch at address zero reaches code. Boot code then jumps into the top bank. The first granted request to that bank sets a single overlay bit. From then on the lowest bank is user RAM, and it stays that way until the next reset. Once the overlay is set, user code may reach the lowest bank, but only the pages that the page checker currently allows.

All outputs are registered. They describe the request sampled on the previous clock edge.

Top module: `bank_gate`

## Requirements
- R1: Address bits [31:30] select the bank. With kernel privilege, bank 1 raises `sel_kram` and bank 2 raises `sel_io`, whatever the overlay state.
- R2: After reset, a kernel request to bank 0 raises `sel_rom`.
- R3: A kernel request to bank 3 raises `sel_rom` and sets the overlay. Every later kernel request to bank 0 raises `sel_uram` until the next reset, and a reset brings bank 0 back to ROM.
- R4: A user request (status bit 7 = 0) to bank 1, 2 or 3, or to bank 0 before the overlay is set, raises `priv_fault` and no chip select.
- R5: With the overlay set, a user request to bank 0 raises `sel_uram` when `page_ok` is 1. When `page_ok` is 0 it raises `page_fault` and no chip select.
- R6: Only status bit 7 sets the privilege. Status bits 6:0 have no effect on any output.
- R7: Outputs are registered. They appear in the cycle after a strobe is sampled. In a cycle after no strobe (`rd_stb` = `wr_stb` = 0), every output is 0, so each fault is a one-cycle pulse.
- R8: `mem_we` is 1 exactly when the sampled request carried `wr_stb` and was granted. `page_ok` has no effect on kernel requests.
- R9: A user request to bank 3 is refused and does not set the overlay.
- R10: At most one chip select is high at a time. `priv_fault` and `page_fault` are never high together, and neither is high alongside a chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Request address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| cpu_status | input | 8 | Processor status byte; bit 7 = 1 means kernel |
| page_ok | input | 1 | Page checker allows the addressed page |
| sel_rom | output | 1 | Boot ROM select |
| sel_uram | output | 1 | User RAM select (bank 0 after overlay) |
| sel_kram | output | 1 | Kernel RAM select (bank 1) |
| sel_io | output | 1 | I/O select (bank 2) |
| mem_we | output | 1 | Write enable for the selected target |
| priv_fault | output | 1 | Privilege violation pulse |
| page_fault | output | 1 | Page violation pulse |

## Verification
The only internal state is the overlay bit. A wrong value in it shows up one cycle after the next bank-0 request. A kernel request then selects the wrong one of `sel_rom` and `sel_uram`. A user request then gives the wrong one of `priv_fault` and `page_fault`/`sel_uram`. The bench therefore sweeps banks, offsets, status bytes, page permissions and strobe kinds in both overlay states. It probes bank 0 directly after every event that could move the bit: reset, a refused user touch of bank 3, the arming kernel touch and a second reset. It also checks that every output falls to zero in the idle cycle after each request.

// File: rtl/bgate_pkg.sv
package bgate_pkg;

    // Bank index, taken from the top address bits
    typedef enum logic [1:0] {
        BK_LOW  = 2'd0,
        BK_KRAM = 2'd1,
        BK_IO   = 2'd2,
        BK_BOOT = 2'd3
    } bank_e;

    // Decoded destination of a request
    typedef enum logic [2:0] {
        TG_NONE = 3'd0,
        TG_ROM  = 3'd1,
        TG_URAM = 3'd2,
        TG_KRAM = 3'd3,
        TG_IO   = 3'd4
    } tgt_e;

    localparam int NUM_TGT  = 4;
    localparam int BANK_W   = 2;
    localparam int PRIV_BIT = 7;

    typedef struct packed {
        tgt_e tgt;
        logic priv_bad;
        logic page_bad;
        logic arms_ovl;
    } verdict_t;

    // One-hot select vector: bit0 ROM, bit1 user RAM, bit2 kernel RAM, bit3 I/O
    function automatic logic [NUM_TGT-1:0] tgt_onehot(input tgt_e t);
        logic [NUM_TGT-1:0] v;
        v = '0;
        case (t)
            TG_ROM:  v[0] = 1'b1;
            TG_URAM: v[1] = 1'b1;
            TG_KRAM: v[2] = 1'b1;
            TG_IO:   v[3] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Access policy for one request
    function automatic verdict_t judge(input bank_e b, input logic kern,
                                       input logic ovl, input logic page_ok);
        verdict_t r;
        r = '{tgt: TG_NONE, priv_bad: 1'b0, page_bad: 1'b0, arms_ovl: 1'b0};
        if (kern) begin
            case (b)
                BK_LOW:  r.tgt = ovl ? TG_URAM : TG_ROM;
                BK_KRAM: r.tgt = TG_KRAM;
                BK_IO:   r.tgt = TG_IO;
                default: begin
                    r.tgt      = TG_ROM;
                    r.arms_ovl = 1'b1;
                end
            endcase
        end else if (b == BK_LOW && ovl) begin
            if (page_ok) r.tgt = TG_URAM;
            else         r.page_bad = 1'b1;
        end else begin
            r.priv_bad = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bgate_bank_split.sv
module bgate_bank_split
    import bgate_pkg::*;
#(
    parameter int HI_W = BANK_W
) (
    input  logic [HI_W-1:0] addr_hi,
    output bank_e           bank
);
    localparam int LSB = HI_W - BANK_W;

    logic [BANK_W-1:0] idx;
    assign idx  = addr_hi[HI_W-1:LSB];
    assign bank = bank_e'(idx);

    generate
        if (LSB > 0) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^addr_hi[LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/bgate_overlay.sv
module bgate_overlay (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic ovl
);
    logic ovl_q;

    always_ff @(posedge clk) begin
        if (rst)      ovl_q <= 1'b0;
        else if (arm) ovl_q <= 1'b1;
    end

    assign ovl = ovl_q;

    // R3
    overlay_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovl_q |=> ovl_q);

    // R3
    overlay_arm_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> ovl_q);
endmodule

// File: rtl/bgate_policy.sv
module bgate_policy
    import bgate_pkg::*;
(
    input  bank_e    bank,
    input  logic     kern,
    input  logic     ovl,
    input  logic     page_ok,
    output verdict_t verdict
);
    always_comb begin
        verdict = judge(bank, kern, ovl, page_ok);
    end
endmodule

// File: rtl/bgate_out_stage.sv
module bgate_out_stage
    import bgate_pkg::*;
#(
    parameter int N_SEL = NUM_TGT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  verdict_t         verdict,
    output logic [N_SEL-1:0] sel,
    output logic             we,
    output logic             priv_f,
    output logic             page_f
);
    logic [N_SEL-1:0] hot;
    logic             granted;

    assign hot     = tgt_onehot(verdict.tgt);
    assign granted = (verdict.tgt != TG_NONE);

    generate
        for (genvar g = 0; g < N_SEL; g++) begin : g_sel
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= req && hot[g];
            end
            assign sel[g] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            we     <= 1'b0;
            priv_f <= 1'b0;
            page_f <= 1'b0;
        end else begin
            we     <= req && wr && granted;
            priv_f <= req && verdict.priv_bad;
            page_f <= req && verdict.page_bad;
        end
    end

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R10
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_f || page_f) |-> (sel == '0 && !(priv_f && page_f)));

    // R8
    we_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (sel != '0));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> (sel == '0 && !we && !priv_f && !page_f));
endmodule

// File: rtl/bank_gate.sv
module bank_gate
    import bgate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [7:0]        cpu_status,
    input  logic              page_ok,
    output logic              sel_rom,
    output logic              sel_uram,
    output logic              sel_kram,
    output logic              sel_io,
    output logic              mem_we,
    output logic              priv_fault,
    output logic              page_fault
);
    localparam int LOW_W = ADDR_W - BANK_W;

    logic             req;
    logic             kern;
    logic             ovl;
    bank_e            bank;
    verdict_t         verdict;
    logic [NUM_TGT-1:0] sel;

    logic unused_low;
    assign unused_low = ^{bus_addr[LOW_W-1:0], cpu_status[PRIV_BIT-1:0]};

    assign req  = rd_stb || wr_stb;
    assign kern = cpu_status[PRIV_BIT];

    bgate_bank_split #(.HI_W(BANK_W)) u_split (
        .addr_hi (bus_addr[ADDR_W-1:LOW_W]),
        .bank    (bank)
    );

    bgate_policy u_policy (
        .bank    (bank),
        .kern    (kern),
        .ovl     (ovl),
        .page_ok (page_ok),
        .verdict (verdict)
    );

    bgate_overlay u_overlay (
        .clk (clk),
        .rst (rst),
        .arm (req && verdict.arms_ovl),
        .ovl (ovl)
    );

    bgate_out_stage #(.N_SEL(NUM_TGT)) u_out (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr      (wr_stb),
        .verdict (verdict),
        .sel     (sel),
        .we      (mem_we),
        .priv_f  (priv_fault),
        .page_f  (page_fault)
    );

    assign sel_rom  = sel[0];
    assign sel_uram = sel[1];
    assign sel_kram = sel[2];
    assign sel_io   = sel[3];

    // R1
    kram_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (req && kern && bus_addr[ADDR_W-1:LOW_W] == 2'd1) |=> sel_kram);

    // R4
    user_io_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !kern && bus_addr[ADDR_W-1:LOW_W] == 2'd2) |=> priv_fault);

    // R3
    boot_fetch_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (req && kern && bus_addr[ADDR_W-1:LOW_W] == 2'd3) |=> sel_rom);
endmodule

// File: tb/test_bank_gate.sv
`timescale 1ns/100ps
module test_bank_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  cpu_status = '0;
    logic        page_ok = 1'b0;
    logic sel_rom, sel_uram, sel_kram, sel_io, mem_we, priv_fault, page_fault;

    int vectors = 0;
    int errors  = 0;
    bit ovl_model = 1'b0;

    always #2.5 clk = ~clk;

    bank_gate i_bank_gate (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .cpu_status(cpu_status), .page_ok(page_ok),
        .sel_rom(sel_rom), .sel_uram(sel_uram), .sel_kram(sel_kram), .sel_io(sel_io),
        .mem_we(mem_we), .priv_fault(priv_fault), .page_fault(page_fault)
    );

    // observed vector: {rom, uram, kram, io, we, priv, page}
    function automatic logic [6:0] observe();
        return {sel_rom, sel_uram, sel_kram, sel_io, mem_we, priv_fault, page_fault};
    endfunction

    task automatic check(input logic [6:0] exp, input string rq);
        vectors++;
        if (observe() !== exp) begin
            errors++;
            $display("FAIL %s addr=%h st=%h pok=%0d rd=%0d wr=%0d got=%b exp=%b",
                     rq, bus_addr, cpu_status, page_ok, rd_stb, wr_stb, observe(), exp);
        end
    endtask

    // Called at a negedge; drives one request, checks it and the idle cycle after it
    task automatic access(input logic [31:0] a, input logic rd, input logic wr,
                          input logic [7:0] st, input logic pok);
        int          bank;
        bit          kern;
        bit          grant;
        logic [6:0]  exp;
        string       rq;
        bank = int'(a[31:30]);
        kern = st[7];
        exp  = '0;
        grant = 1'b1;
        if (!kern) begin
            if (bank == 0 && ovl_model) begin
                rq = "R5";
                if (pok) exp[5] = 1'b1;
                else begin exp[0] = 1'b1; grant = 1'b0; end
            end else begin
                rq = (bank == 3) ? "R9" : "R4";
                exp[1] = 1'b1;
                grant  = 1'b0;
            end
        end else begin
            case (bank)
                0: begin rq = ovl_model ? "R3" : "R2"; exp[ovl_model ? 5 : 6] = 1'b1; end
                1: begin rq = "R1"; exp[4] = 1'b1; end
                2: begin rq = "R1"; exp[3] = 1'b1; end
                default: begin rq = "R3"; exp[6] = 1'b1; end
            endcase
        end
        if (wr && grant) exp[2] = 1'b1;   // R8
        if (st[6:0] != 7'h00) rq = {rq, "/R6"};
        bus_addr = a; rd_stb = rd; wr_stb = wr; cpu_status = st; page_ok = pok;
        @(negedge clk);
        check(exp, rq);
        if (kern && bank == 3) ovl_model = 1'b1;
        rd_stb = 1'b0; wr_stb = 1'b0;
        @(negedge clk);
        check(7'b0, "R7");
    endtask

    task automatic do_reset();
        rst = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0;
        @(negedge clk); @(negedge clk);
        check(7'b0, "R7");   // reset state: all outputs low
        rst = 1'b0;
        ovl_model = 1'b0;
        @(negedge clk);
    endtask

    // Sweep; skip_boot_kernel avoids arming the overlay mid-sweep
    task automatic sweep(input bit skip_boot_kernel);
        logic [29:0] offs [3];
        logic [7:0]  stats [6];
        offs[0] = 30'h0; offs[1] = 30'h12345678; offs[2] = 30'h3FFFFFFF;
        stats[0] = 8'h00; stats[1] = 8'h7F; stats[2] = 8'h80;
        stats[3] = 8'hFF; stats[4] = 8'h2A; stats[5] = 8'hB0;
        for (int b = 0; b < 4; b++)
            for (int o = 0; o < 3; o++)
                for (int s = 0; s < 6; s++)
                    for (int p = 0; p < 2; p++)
                        for (int k = 0; k < 3; k++) begin
                            if (!(skip_boot_kernel && b == 3 && stats[s][7]))
                                access({b[1:0], offs[o]}, k != 1, k != 0, stats[s], p[0]);
                        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R2: boot alias right after reset
        access(32'h0000_0000, 1'b1, 1'b0, 8'h80, 1'b0);
        // R9: user probe of bank 3 is refused and does not arm the overlay
        access(32'hC000_0010, 1'b1, 1'b0, 8'h00, 1'b1);
        access(32'h0000_0100, 1'b1, 1'b0, 8'h80, 1'b1);
        sweep(1'b1);
        // R3: arming kernel access to bank 3, then bank 0 flips to user RAM
        access(32'hC000_0004, 1'b1, 1'b0, 8'h80, 1'b0);
        access(32'h0000_0000, 1'b1, 1'b0, 8'h80, 1'b0);
        access(32'h0000_0040, 1'b0, 1'b1, 8'h00, 1'b1);
        access(32'h0000_0040, 1'b0, 1'b1, 8'h00, 1'b0);
        sweep(1'b0);
        // R3: reset restores the boot alias
        do_reset();
        access(32'h0000_0000, 1'b1, 1'b1, 8'h80, 1'b1);
        access(32'h0000_0000, 1'b1, 1'b0, 8'h7F, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule